// File: doc/BRIEF.md
# SPI Command Queue and Status Controller

This block is the queueing and status part of a memory-mapped SPI master. Software writes 32-bit command words over a simple register bus into a small transmit queue. The block passes them one at a time to a separate serial frame engine, which does the bit shifting and timing. The engine answers each frame with a completion pulse and a 16-bit received word. That word lands in a receive queue, and software pops it through a register. Each completion bumps a 16-bit frame counter and sets a sticky completion flag.

A command word can mark itself as the end of a queue. Once that frame completes, a separate sticky flag rises and issuing stops until software clears the flag. This lets software load a batch, sleep until the interrupt, and resume. A command can also zero the frame counter before its own frame is counted. Because the counter wraps, software can measure progress as a modular difference. The status flags are cleared by writing one. Two enable bits route the flags onto a single interrupt line. A control register carries a master-mode enable, six chip-select idle levels and two self-clearing flush strobes.

Register offsets (byte addresses): control 0x00, frame count 0x04, status 0x08, interrupt enable 0x0C, push 0x10, pop 0x14. Reads are combinational from the address. A received frame that finds the receive queue full is discarded.

Top module: `spiq_ctrl`

## Requirements
- R1: After reset the status reads 0, the frame count reads 0, both queues are empty, `irq`, `eng_cmd_valid`, `master_en` and `cs_idle` are low.
- R2: The transmit queue holds 4 command words; a push at offset 0x10 to a full queue is discarded, and the stored words reach the engine in push order.
- R3: A command is offered on `eng_cmd_valid` only while control bit 31 (master enable) is 1, and no new command is offered while a frame is in flight (between acceptance and `eng_frame_done`).
- R4: Each `eng_frame_done` stores `eng_rx_data` in the receive queue, sets status bit 31 (frame-complete flag) and increments the counter in bits 31:16 of offset 0x04; a read at offset 0x14 returns the oldest word in bits 15:0 and removes it.
- R5: When a frame whose command had bit 27 set completes, status bit 28 (end-of-queue flag) sets and no further command is offered until that flag is cleared.
- R6: A write to the status register clears exactly the flags written as 1 (bits 31 and 28) and leaves the others unchanged.
- R7: `irq` is high exactly when (status bit 31 and enable bit 31 at offset 0x0C) or (status bit 28 and enable bit 28) are both set.
- R8: The frame counter is 16 bits wide and wraps from 65535 to 0; a command with bit 26 set clears the counter before its own frame is counted, so it reads 1 after that frame.
- R9: Writing control bit 11 as 1 empties the transmit queue, writing bit 10 as 1 empties the receive queue; both read back as 0.
- R10: A pop from an empty receive queue returns 0 and changes no queue state.
- R11: Control bit 31 drives `master_en` and bits 21:16 drive `cs_idle`; both read back from offset 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at offset 0x14) |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| eng_cmd_valid | output | 1 | A command word is offered to the engine |
| eng_cmd_ready | input | 1 | Engine accepts the offered command |
| eng_cmd | output | 32 | Command word offered to the engine |
| eng_frame_done | input | 1 | One-cycle pulse: the in-flight frame finished |
| eng_rx_data | input | 16 | Word received during the finished frame |
| master_en | output | 1 | Master-mode enable from control bit 31 |
| cs_idle | output | 6 | Idle levels of the chip selects |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several invariants. Nothing is offered when master mode is off or while the end-of-queue flag is set. At most one frame is in flight. Queue occupancy never passes its depth. The counter holds between completions and steps or restarts at each one. Set flags stay set until written. The interrupt stays low with no flag set. Several behaviours only the bench scenarios can show: drop-on-full, ordering and data integrity through both queues, the exact bits cleared by a status write, the flush strobes and their read-back, and the counter actually wrapping after 65536 frames.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

    localparam int BUS_W    = 32;
    localparam int CMD_W    = 32;
    localparam int RX_W     = 16;
    localparam int CNT_W    = 16;
    localparam int CS_N     = 6;

    // register byte offsets
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_CNT  = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_IEN  = 'h0C;
    localparam int OFS_PUSH = 'h10;
    localparam int OFS_POP  = 'h14;

    // control fields
    localparam int B_MASTER   = 31;
    localparam int B_FLUSH_TX = 11;
    localparam int B_FLUSH_RX = 10;
    localparam int B_CS_LO    = 16;

    // status / enable fields
    localparam int B_TCF  = 31;
    localparam int B_EOQF = 28;

    // command word flags
    localparam int B_CMD_EOQ = 27;
    localparam int B_CMD_CTC = 26;

    localparam int B_CNT_LO = BUS_W - CNT_W;

    typedef struct packed {
        logic eoq;
        logic ctc;
    } fr_tag_t;

    typedef struct packed {
        logic            master;
        logic [CS_N-1:0] cs_idle;
    } ctrl_t;

    typedef struct packed {
        logic tcf;
        logic eoqf;
    } flags_t;

    function automatic logic [BUS_W-1:0] ctrl_word(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[B_MASTER] = c.master;
        w[B_CS_LO +: CS_N] = c.cs_idle;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] flag_word(input flags_t f);
        logic [BUS_W-1:0] w;
        w = '0;
        w[B_TCF]  = f.tcf;
        w[B_EOQF] = f.eoqf;
        return w;
    endfunction

endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  wr_ptr, rd_ptr;
    logic         do_push, do_pop;

    assign count   = wr_ptr - rd_ptr;
    assign full    = (count == (PW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rd_ptr[PW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr[PW-1:0]] <= wdata;
    end

endmodule

// File: rtl/spiq_issue.sv
module spiq_issue
    import spiq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             master_en,
    input  logic             halt,
    input  logic             q_empty,
    input  logic [CMD_W-1:0] q_head,
    input  logic             eng_ready,
    input  logic             frame_done,
    output logic             eng_valid,
    output logic [CMD_W-1:0] eng_cmd,
    output logic             q_pop,
    output logic             busy,
    output fr_tag_t          tag
);
    assign eng_valid = master_en && !halt && !busy && !q_empty;
    assign eng_cmd   = q_head;
    assign q_pop     = eng_valid && eng_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            tag  <= '0;
        end else if (q_pop) begin
            busy    <= 1'b1;
            tag.eoq <= q_head[B_CMD_EOQ];
            tag.ctc <= q_head[B_CMD_CTC];
        end else if (frame_done) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/spiq_status.sv
module spiq_status
    import spiq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_done,
    input  fr_tag_t          tag,
    input  flags_t           clr,
    input  flags_t           ien,
    output flags_t           flags,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            cnt   <= '0;
        end else begin
            flags.tcf  <= frame_done || (flags.tcf && !clr.tcf);
            flags.eoqf <= (frame_done && tag.eoq) || (flags.eoqf && !clr.eoqf);
            if (frame_done)
                cnt <= tag.ctc ? CNT_W'(1) : cnt + 1'b1;
        end
    end

    assign irq = |(flags & ien);

endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl
    import spiq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              eng_cmd_valid,
    input  logic              eng_cmd_ready,
    output logic [CMD_W-1:0]  eng_cmd,
    input  logic              eng_frame_done,
    input  logic [RX_W-1:0]   eng_rx_data,
    output logic              master_en,
    output logic [CS_N-1:0]   cs_idle,
    output logic              irq
);
    localparam int TXC_W = $clog2(TX_DEPTH) + 1;
    localparam int RXC_W = $clog2(RX_DEPTH) + 1;

    ctrl_t            ctrl_q;
    flags_t           ien_q, clr, flags;
    fr_tag_t          tag;
    logic             wr_ctrl, wr_stat, wr_ien, wr_push, rd_pop;
    logic             flush_tx, flush_rx;
    logic             tx_pop, tx_full, tx_empty, rx_full, rx_empty, busy;
    logic [CMD_W-1:0] tx_head;
    logic [RX_W-1:0]  rx_head;
    logic [TXC_W-1:0] tx_count;
    logic [RXC_W-1:0] rx_count;
    logic [CNT_W-1:0] cnt;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_ien   = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
    assign wr_push  = bus_wr && (bus_addr == ADDR_W'(OFS_PUSH));
    assign rd_pop   = bus_rd && (bus_addr == ADDR_W'(OFS_POP));
    assign flush_tx = wr_ctrl && bus_wdata[B_FLUSH_TX];
    assign flush_rx = wr_ctrl && bus_wdata[B_FLUSH_RX];
    assign clr.tcf  = wr_stat && bus_wdata[B_TCF];
    assign clr.eoqf = wr_stat && bus_wdata[B_EOQF];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.master  <= bus_wdata[B_MASTER];
                ctrl_q.cs_idle <= bus_wdata[B_CS_LO +: CS_N];
            end
            if (wr_ien) begin
                ien_q.tcf  <= bus_wdata[B_TCF];
                ien_q.eoqf <= bus_wdata[B_EOQF];
            end
        end
    end

    assign master_en = ctrl_q.master;
    assign cs_idle   = ctrl_q.cs_idle;

    spiq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(flush_tx),
        .push(wr_push), .wdata(bus_wdata),
        .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty), .count(tx_count)
    );

    spiq_fifo #(.W(RX_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush_rx),
        .push(eng_frame_done), .wdata(eng_rx_data),
        .pop(rd_pop), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty), .count(rx_count)
    );

    spiq_issue u_issue (
        .clk(clk), .rst(rst),
        .master_en(ctrl_q.master), .halt(flags.eoqf),
        .q_empty(tx_empty), .q_head(tx_head),
        .eng_ready(eng_cmd_ready), .frame_done(eng_frame_done),
        .eng_valid(eng_cmd_valid), .eng_cmd(eng_cmd),
        .q_pop(tx_pop), .busy(busy), .tag(tag)
    );

    spiq_status u_status (
        .clk(clk), .rst(rst),
        .frame_done(eng_frame_done), .tag(tag),
        .clr(clr), .ien(ien_q),
        .flags(flags), .cnt(cnt), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): bus_rdata = ctrl_word(ctrl_q);
            ADDR_W'(OFS_CNT):  bus_rdata[B_CNT_LO +: CNT_W] = cnt;
            ADDR_W'(OFS_STAT): bus_rdata = flag_word(flags);
            ADDR_W'(OFS_IEN):  bus_rdata = flag_word(ien_q);
            ADDR_W'(OFS_POP):  bus_rdata[RX_W-1:0] = rx_head;
            default:           bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spiq_ctrl_chk.sv
module spiq_ctrl_chk
    import spiq_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           eng_cmd_valid,
    input logic                           eng_cmd_ready,
    input logic                           eng_frame_done,
    input logic                           master_en,
    input logic                           irq,
    input flags_t                         flags,
    input flags_t                         clr,
    input fr_tag_t                        tag,
    input logic                           busy,
    input logic                           tx_full,
    input logic                           rx_full,
    input logic                           rx_empty,
    input logic [$clog2(TX_DEPTH):0]      tx_count,
    input logic [$clog2(RX_DEPTH):0]      rx_count,
    input logic [CNT_W-1:0]               cnt
);
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid && eng_cmd_ready) |=> !eng_cmd_valid); // R3
    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> !eng_cmd_valid); // R3
    AST_BUSY_GATE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !eng_cmd_valid); // R3
    AST_EOQ_HALT: assert property (@(posedge clk) disable iff (rst)
        flags.eoqf |-> !eng_cmd_valid); // R5
    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= ($clog2(TX_DEPTH)+1)'(TX_DEPTH)) && (tx_full == (tx_count == ($clog2(TX_DEPTH)+1)'(TX_DEPTH)))); // R2
    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (rx_count <= ($clog2(RX_DEPTH)+1)'(RX_DEPTH)) && (rx_empty == (rx_count == '0)) && !(rx_full && rx_empty)); // R4
    AST_DONE_SETS_TCF: assert property (@(posedge clk) disable iff (rst)
        eng_frame_done |=> flags.tcf); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eng_frame_done |=> $stable(cnt)); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (eng_frame_done && !tag.ctc) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R8
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (eng_frame_done && tag.ctc) |=> (cnt == CNT_W'(1))); // R8
    AST_TCF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.tcf && !clr.tcf) |=> flags.tcf); // R6
    AST_EOQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.eoqf && !clr.eoqf) |=> flags.eoqf); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!flags.tcf && !flags.eoqf) |-> !irq); // R7
endmodule

bind spiq_ctrl spiq_ctrl_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst(rst),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_frame_done(eng_frame_done), .master_en(master_en), .irq(irq),
    .flags(flags), .clr(clr), .tag(tag), .busy(busy),
    .tx_full(tx_full), .rx_full(rx_full), .rx_empty(rx_empty),
    .tx_count(tx_count), .rx_count(rx_count), .cnt(cnt)
);

// File: tb/spiq_ctrl_tb.sv
`timescale 1ns/1ps
module spiq_ctrl_tb;
    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_STAT = 8'h08,
                           A_IEN = 8'h0C, A_PUSH = 8'h10, A_POP = 8'h14;
    localparam logic [31:0] M_ON = 32'h8000_0000;

    // {command, expected popped word, expected counter}
    localparam logic [63:0] VEC [6] = '{
        {32'h0000_1234, 16'hEDCB, 16'd5},
        {32'h0000_FFFF, 16'h0000, 16'd6},
        {32'h0400_00A5, 16'hFF5A, 16'd1},
        {32'h0000_8001, 16'h7FFE, 16'd2},
        {32'h0400_0000, 16'hFFFF, 16'd1},
        {32'h0000_5555, 16'hAAAA, 16'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_cmd_valid, eng_cmd_ready;
    logic [31:0] eng_cmd;
    logic        eng_frame_done = 1'b0;
    logic [15:0] eng_rx_data = '0;
    logic        master_en, irq;
    logic [5:0]  cs_idle;

    int n_checks = 0, n_fail = 0;
    int ncmd = 0, n_frames = 0, viol = 0, eng_lat = 1;
    logic [31:0] cmd_log [64];

    always #10 clk = ~clk;
    assign eng_cmd_ready = 1'b1;

    spiq_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
        .eng_cmd(eng_cmd), .eng_frame_done(eng_frame_done),
        .eng_rx_data(eng_rx_data), .master_en(master_en),
        .cs_idle(cs_idle), .irq(irq)
    );

    // serial engine model: returns the inverted low half of each command
    initial begin
        logic [31:0] cap;
        forever begin
            @(posedge clk);
            if (!rst && eng_cmd_valid === 1'b1 && eng_cmd_ready) begin
                cap = eng_cmd;
                if (ncmd < 64) cmd_log[ncmd] = cap;
                ncmd++;
                for (int k = 1; k < eng_lat; k++) begin
                    @(posedge clk);
                    if (eng_cmd_valid) viol++;
                end
                eng_frame_done <= 1'b1;
                eng_rx_data    <= ~cap[15:0];
                @(posedge clk);
                eng_frame_done <= 1'b0;
                n_frames++;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int n0, base;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 valid", {31'd0, eng_cmd_valid}, 32'd0);
        chk("R1 master/cs", {25'd0, master_en, cs_idle}, 32'd0);
        rd(A_STAT, v); chk("R1 status", v, 32'd0);
        rd(A_CNT, v);  chk("R1 count", v, 32'd0);
        rd(A_POP, v);  chk("R1 R10 empty pop", v, 32'd0);

        // R11 control fields
        wr(A_CTRL, 32'h802A_0000);
        chk("R11 master_en", {31'd0, master_en}, 32'd1);
        chk("R11 cs_idle", {26'd0, cs_idle}, 32'h2A);
        rd(A_CTRL, v); chk("R11 readback", v, 32'h802A_0000);
        wr(A_CTRL, 32'h0);

        // R2 depth and order, R3 gating and one-in-flight
        for (int i = 0; i < 5; i++) wr(A_PUSH, 32'h0000_1000 + i);
        idle(3);
        chk("R3 gated by master bit", {31'd0, eng_cmd_valid}, 32'd0);
        eng_lat = 3;
        wr(A_CTRL, M_ON);
        idle(40);
        chk("R2 fifth push dropped", ncmd, 4);
        for (int i = 0; i < 4; i++) chk("R2 order", cmd_log[i], 32'h0000_1000 + i);
        chk("R3 nothing offered in flight", viol, 0);
        rd(A_CNT, v);  chk("R4 count", v >> 16, 32'd4);
        rd(A_STAT, v); chk("R4 tcf", v, 32'h8000_0000);
        for (int i = 0; i < 4; i++) begin
            rd(A_POP, v); chk("R4 pop data", v, 32'h0000_EFFF - i);
        end
        rd(A_POP, v); chk("R10 pop empty", v, 32'd0);
        eng_lat = 1;

        // vector table: R4 data path, R8 counter clear
        for (int i = 0; i < 6; i++) begin
            wr(A_PUSH, VEC[i][63:32]);
            idle(8);
            rd(A_POP, v); chk("R4 table pop", v, {16'd0, VEC[i][31:16]});
            rd(A_CNT, v); chk("R8 table count", v >> 16, {16'd0, VEC[i][15:0]});
        end

        // R6 write-one-to-clear
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R6 zero write keeps", v, 32'h8000_0000);
        wr(A_STAT, 32'h1000_0000);
        rd(A_STAT, v); chk("R6 other bit keeps", v, 32'h8000_0000);
        wr(A_STAT, 32'h8000_0000);
        rd(A_STAT, v); chk("R6 clear", v, 32'h0);

        // R5 end-of-queue halt, R7 interrupt routing
        n0 = ncmd;
        wr(A_PUSH, 32'h0800_0011);
        wr(A_PUSH, 32'h0000_0022);
        idle(20);
        chk("R5 halted after eoq", ncmd, n0 + 1);
        chk("R5 no offer", {31'd0, eng_cmd_valid}, 32'd0);
        rd(A_STAT, v); chk("R5 eoq flag", v, 32'h9000_0000);
        chk("R7 disabled", {31'd0, irq}, 32'd0);
        wr(A_IEN, 32'h1000_0000);
        chk("R7 eoq enabled", {31'd0, irq}, 32'd1);
        wr(A_IEN, 32'h8000_0000);
        chk("R7 tcf enabled", {31'd0, irq}, 32'd1);
        wr(A_STAT, 32'h8000_0000);
        chk("R7 tcf cleared", {31'd0, irq}, 32'd0);
        wr(A_IEN, 32'h1000_0000);
        chk("R7 eoq again", {31'd0, irq}, 32'd1);
        wr(A_STAT, 32'h1000_0000);
        idle(10);
        chk("R5 resumed", ncmd, n0 + 2);
        chk("R5 resumed cmd", cmd_log[n0 + 1], 32'h0000_0022);
        chk("R7 eoq gone", {31'd0, irq}, 32'd0);
        rd(A_STAT, v); chk("R5 flag clear", v, 32'h8000_0000);
        rd(A_POP, v); rd(A_POP, v);

        // R9 flushes
        wr(A_CTRL, 32'h0);
        for (int i = 0; i < 3; i++) wr(A_PUSH, 32'h0000_0300 + i);
        n0 = ncmd;
        wr(A_CTRL, 32'h0000_0800);
        wr(A_CTRL, M_ON);
        idle(10);
        chk("R9 tx flushed", ncmd, n0);
        rd(A_CTRL, v); chk("R9 strobes read 0", v, M_ON);
        wr(A_PUSH, 32'h0000_0401);
        wr(A_PUSH, 32'h0000_0402);
        idle(10);
        chk("R9 frames ran", ncmd, n0 + 2);
        wr(A_CTRL, M_ON | 32'h0000_0400);
        rd(A_POP, v); chk("R9 rx flushed", v, 32'd0);

        // R8 counter wrap
        wr(A_PUSH, 32'h0400_0000);
        idle(10);
        base = n_frames - 1;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_PUSH; bus_wdata = 32'h0000_0001;
        while (n_frames - base < 65538) @(negedge clk);
        bus_wr = 1'b0;
        idle(20);
        rd(A_CNT, v);
        chk("R8 wrap", v >> 16, (n_frames - base) % 65536);

        summary();
        $finish;
    end
endmodule